// File: doc/BRIEF.md
# Token-Gated Locally Clocked Channel Receiver

This block is the receiving end of a data-driven link between two processing modules that each run on their own clock. The sender announces every new word by toggling a single request wire, so both a rising and a falling transition carry one token. The receiver notices the transition, captures the data word and then enables a local clock whose period is set by software. That clock drives the consuming module's synchronous logic. The clock stops again once no token is pending and a short drain tail has elapsed. When the consumer takes the word, the receiver toggles an acknowledge wire back to the sender.

In RTL the local oscillator is modelled as a programmable divider running from a free reference clock. The consumer signals that it has taken the word on `cons_i`. This input is sampled on the reference edge where the local clock rises. Because the local clock only ever starts in response to a captured token, the consumer never samples a request that is still changing. A status output shows when the local clock is running so that power can be monitored.

Top module: `tgc_rx`

## Requirements
- R1: Each transition of `req_i` in either direction is one token. A token is pending while the synchronised request differs from a stored phase bit. `tok_o` rises SYNC_STAGES+1 reference cycles after the transition (3 with defaults).
- R2: `word_o` takes the value of `data_i` on the same edge that `tok_o` rises, and holds it until the word is consumed.
- R3: With no token pending and the drain tail spent, `lclk_o` and `run_o` stay low. This is also the state after reset, together with `tok_o` and `ack_o` low.
- R4: `run_o` rises one reference cycle after `tok_o`, with `lclk_o` still low.
- R5: An 8-bit period value N gives local-clock half-periods of N+1 reference cycles, so the first rise comes N+1 cycles after `run_o` rises. A write on `per_wr_i` is taken only while `run_o` is low and is ignored while the clock runs. The reset value of N is 3.
- R6: When `cons_i` is high at a local-clock rise while a token is pending, `ack_o` toggles and `tok_o` falls on that edge.
- R7: After the consuming rise, the local clock gives exactly DRAIN further rises (default 2) when no new token arrives. It then stops at the next fall, and `run_o` falls on that same edge.
- R8: Consecutive words sent on the channel appear on `word_o` in the order they were sent.
- R9: While a token is pending and not consumed, the local clock keeps running and `ack_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock standing in for the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Two-phase request from the sender |
| data_i | input | DW | Data word held by the sender until acknowledge |
| ack_o | output | 1 | Two-phase acknowledge back to the sender |
| cons_i | input | 1 | Consumer takes the word at the next local-clock rise |
| per_wr_i | input | 1 | Period write strobe |
| per_val_i | input | 8 | Period value N (half-period N+1) |
| word_o | output | DW | Captured data word |
| tok_o | output | 1 | Token pending, word valid |
| lclk_o | output | 1 | Gated local clock |
| run_o | output | 1 | Local clock running (power status) |

## Verification
Each result falls on a fixed reference edge after the request transition. With two synchroniser stages, `tok_o` and `word_o` appear on edge 3 and `run_o` on edge 4. Local rise r falls on edge 4+(2r-1)(N+1), and the acknowledge toggles on the rise where `cons_i` was presented. The clock stops on edge 4+2(W+DRAIN)(N+1), where W is the index of the consuming rise. The bench counts edges from the transition, samples on the falling edge of the reference clock, and checks each output on the step its formula gives and on the step before it. It does this for several periods and consuming-rise indices, including period writes made while the clock runs.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  localparam int PER_W = 8;
  typedef logic [PER_W-1:0] per_t;
endpackage

// File: rtl/tgc_sync.sv
module tgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_n = d_i;
    end else begin : g_many
      always_comb sh_n = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tgc_token.sv
module tgc_token #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic          valid_o,
  output logic [DW-1:0] word_o,
  output logic          ack_o
);
  logic          phase_q, phase_n;
  logic          valid_q, valid_n;
  logic          ack_q, ack_n;
  logic [DW-1:0] word_q, word_n;
  logic          pend;
  logic          word_en;

  assign pend = req_s_i ^ phase_q;

  always_comb begin
    phase_n = phase_q;
    valid_n = valid_q;
    ack_n   = ack_q;
    word_en = 1'b0;
    if (take_i) begin
      phase_n = ~phase_q;
      ack_n   = ~ack_q;
      valid_n = 1'b0;
    end else if (pend && !valid_q) begin
      valid_n = 1'b1;
      word_en = 1'b1;
    end
    word_n = word_en ? data_i : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      valid_q <= 1'b0;
      ack_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      phase_q <= phase_n;
      valid_q <= valid_n;
      ack_q   <= ack_n;
      word_q  <= word_n;
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/tgc_lclk.sv
module tgc_lclk
  import tgc_pkg::*;
#(
  parameter int DRAIN   = 2,
  parameter int PER_RST = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_i,
  input  logic take_i,
  input  logic per_wr_i,
  input  per_t per_val_i,
  output logic lclk_o,
  output logic run_o,
  output logic rise_o,
  output per_t per_o
);
  localparam int CW = $clog2(DRAIN + 2);

  logic          run_q, run_n;
  logic          lclk_q, lclk_n;
  per_t          cnt_q, cnt_n;
  per_t          per_q, per_n;
  logic [CW-1:0] drn_q, drn_n;
  logic          flip, rise, fall;

  assign flip = run_q && (cnt_q == per_q);
  assign rise = flip && !lclk_q;
  assign fall = flip && lclk_q;

  always_comb begin
    run_n  = run_q;
    lclk_n = lclk_q;
    cnt_n  = cnt_q;
    per_n  = per_q;
    drn_n  = drn_q;
    if (!run_q) begin
      cnt_n  = '0;
      lclk_n = 1'b0;
      drn_n  = '0;
      if (per_wr_i) per_n = per_val_i;
      if (tok_i)    run_n = 1'b1;
    end else begin
      if (flip) begin
        cnt_n  = '0;
        lclk_n = ~lclk_q;
      end else begin
        cnt_n = cnt_q + per_t'(1);
      end
      if (rise) begin
        if (take_i)                       drn_n = CW'(DRAIN);
        else if (!tok_i && drn_q != '0)   drn_n = drn_q - CW'(1);
      end
      if (fall && !tok_i && drn_q == '0) begin
        run_n  = 1'b0;
        lclk_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      lclk_q <= 1'b0;
      cnt_q  <= '0;
      per_q  <= per_t'(PER_RST);
      drn_q  <= '0;
    end else begin
      run_q  <= run_n;
      lclk_q <= lclk_n;
      cnt_q  <= cnt_n;
      per_q  <= per_n;
      drn_q  <= drn_n;
    end
  end

  assign lclk_o = lclk_q;
  assign run_o  = run_q;
  assign rise_o = rise;
  assign per_o  = per_q;
endmodule

// File: rtl/tgc_rx.sv
module tgc_rx
  import tgc_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DRAIN       = 2,
  parameter int PER_RST     = 3
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [DW-1:0] data_i,
  output logic          ack_o,
  input  logic          cons_i,
  input  logic          per_wr_i,
  input  logic [7:0]    per_val_i,
  output logic [DW-1:0] word_o,
  output logic          tok_o,
  output logic          lclk_o,
  output logic          run_o
);
  logic [1:0] rs_q;
  logic       rst_i_n;
  logic       req_s;
  logic       rise;
  logic       take;
  per_t       per_cur;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  tgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (ref_clk),
    .rst_n (rst_i_n),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  assign take = rise && cons_i && tok_o;

  tgc_token #(.DW(DW)) u_token (
    .clk     (ref_clk),
    .rst_n   (rst_i_n),
    .req_s_i (req_s),
    .data_i  (data_i),
    .take_i  (take),
    .valid_o (tok_o),
    .word_o  (word_o),
    .ack_o   (ack_o)
  );

  tgc_lclk #(.DRAIN(DRAIN), .PER_RST(PER_RST)) u_lclk (
    .clk       (ref_clk),
    .rst_n     (rst_i_n),
    .tok_i     (tok_o),
    .take_i    (take),
    .per_wr_i  (per_wr_i),
    .per_val_i (per_t'(per_val_i)),
    .lclk_o    (lclk_o),
    .run_o     (run_o),
    .rise_o    (rise),
    .per_o     (per_cur)
  );
endmodule

// File: rtl/tgc_rx_chk.sv
module tgc_rx_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tok,
  input logic          run,
  input logic          lclk,
  input logic          ack,
  input logic [DW-1:0] word,
  input logic [7:0]    per
);
  assert_lclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !lclk);

  assert_start_on_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(tok));

  assert_rise_while_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lclk) |-> run);

  assert_period_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(per));

  assert_ack_needs_token_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != $past(ack)) |-> $past(tok));

  assert_stop_without_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !$past(tok));

  assert_word_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tok && $past(tok)) |-> $stable(word));
endmodule

bind tgc_rx tgc_rx_chk #(.DW(DW)) u_chk (
  .clk  (ref_clk),
  .rst_n(rst_n),
  .tok  (tok_o),
  .run  (run_o),
  .lclk (lclk_o),
  .ack  (ack_o),
  .word (word_o),
  .per  (per_cur)
);

// File: tb/tgc_rx_tb.sv
`timescale 1ns/1ps
module tgc_rx_tb;
  localparam int DW    = 16;
  localparam int SYNC  = 2;
  localparam int DRAIN = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_i, cons_i, per_wr_i;
  logic [DW-1:0] data_i;
  logic [7:0]    per_val_i;
  logic          ack_o, tok_o, lclk_o, run_o;
  logic [DW-1:0] word_o;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2.5 clk = ~clk;

  tgc_rx u_dut (
    .ref_clk  (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .data_i   (data_i),
    .ack_o    (ack_o),
    .cons_i   (cons_i),
    .per_wr_i (per_wr_i),
    .per_val_i(per_val_i),
    .word_o   (word_o),
    .tok_o    (tok_o),
    .lclk_o   (lclk_o),
    .run_o    (run_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_per(input int per);
    @(negedge clk);
    per_wr_i  = 1'b1;
    per_val_i = 8'(per);
    @(negedge clk);
    per_wr_i  = 1'b0;
  endtask

  // One transfer: consume at local rise w, expect DRAIN further rises, then stop.
  task automatic xfer(input int per, input int w, input logic [DW-1:0] d, input bit poke);
    int   base  = SYNC + 2;
    int   rw    = base + (2 * w - 1) * (per + 1);
    int   stop  = base + 2 * (w + DRAIN) * (per + 1);
    int   rises = 0;
    int   first = -1;
    logic ack0  = ack_o;
    logic pl    = lclk_o;
    req_i  = ~req_i;
    data_i = d;
    for (int s = 1; s <= stop + 4; s++) begin
      @(negedge clk);
      if (lclk_o && !pl) begin
        rises++;
        if (first < 0) first = s;
      end
      pl = lclk_o;
      if (s == SYNC)     chk(tok_o == 1'b0, "R1 token early", int'(tok_o), 0);
      if (s == SYNC + 1) begin
        chk(tok_o == 1'b1, "R1 token", int'(tok_o), 1);
        chk(word_o == d, "R2 R8 word", int'(word_o), int'(d));
        chk(run_o == 1'b0, "R4 run early", int'(run_o), 0);
      end
      if (s == base) begin
        chk(run_o == 1'b1, "R4 run", int'(run_o), 1);
        chk(lclk_o == 1'b0, "R4 lclk low", int'(lclk_o), 0);
      end
      if (s == rw - 1) begin
        chk(ack_o == ack0, "R9 ack held", int'(ack_o), int'(ack0));
        chk(tok_o == 1'b1, "R9 token held", int'(tok_o), 1);
        chk(word_o == d, "R2 word held", int'(word_o), int'(d));
      end
      if (s == rw) begin
        chk(ack_o == ~ack0, "R6 ack toggle", int'(ack_o), int'(~ack0));
        chk(tok_o == 1'b0, "R6 token clear", int'(tok_o), 0);
      end
      if (s == stop - 1) chk(run_o == 1'b1, "R7 still running", int'(run_o), 1);
      if (s == stop) begin
        chk(run_o == 1'b0, "R7 stopped", int'(run_o), 0);
        chk(lclk_o == 1'b0, "R7 lclk low", int'(lclk_o), 0);
      end
      if (s == stop + 4) chk(lclk_o == 1'b0 && run_o == 1'b0, "R3 stays idle",
                             int'(lclk_o), 0);
      cons_i    = (s == rw - 1);
      per_wr_i  = poke && (s == base);
      per_val_i = poke ? 8'h55 : per_val_i;
    end
    per_wr_i = 1'b0;
    chk(first == base + per + 1, "R5 first rise", first, base + per + 1);
    chk(rises == w + DRAIN, "R7 rise count", rises, w + DRAIN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pers[4] = '{0, 1, 2, 7};
    rst_n = 1'b0; req_i = 1'b0; cons_i = 1'b0; per_wr_i = 1'b0;
    data_i = '0; per_val_i = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3: reset state
    chk(tok_o == 1'b0, "R3 reset tok", int'(tok_o), 0);
    chk(run_o == 1'b0, "R3 reset run", int'(run_o), 0);
    chk(lclk_o == 1'b0, "R3 reset lclk", int'(lclk_o), 0);
    chk(ack_o == 1'b0, "R3 reset ack", int'(ack_o), 0);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (lclk_o || run_o) seen++;
      end
      chk(seen == 0, "R3 idle gated", seen, 0);
    end
    // R5: reset period value 3
    xfer(3, 1, 16'hA5C3, 1'b0);
    // Period sweep; write during running must be ignored (R5)
    for (int i = 0; i < 4; i++) begin
      set_per(pers[i]);
      xfer(pers[i], 1, 16'h1000 + 16'(i), 1'b1);
      xfer(pers[i], 3, 16'h2F00 + 16'(i * 7), 1'b0);
    end
    // R8: back-to-back words in order
    for (int i = 0; i < 3; i++) xfer(7, 1, 16'hC000 + 16'(i * 3), 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule